// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks the operands of the ALU in the execute stage of a five-stage, eight-register load-store pipeline. Decode reads the register file and writeback writes it, so an instruction that follows a producer closely would get an old value. The unit compares each source register of the instruction in execute with the destinations of the three older instructions still in flight. These are the one holding its ALU result before memory, the one leaving memory with its ALU or load result, and the one held in the writeback latch. When a match is found, the unit replaces the register-file data with the in-flight result.

The logic is purely combinational and sits in front of the ALU input multiplexers. Every source works the same way. A compare counts only when the older instruction writes a register. The youngest matching producer wins. A source naming register 0 always keeps the register-file data, since that register reads as zero. For each operand the unit gives a 2-bit select code and the chosen value.

Top module: `operand_fwd_unit`

## Requirements
- R1: When no valid older destination equals a source register, that operand's select code is 0 and its value equals the register-file read data for that operand.
- R2: When the memory-stage instruction (exm_*) writes the source register, the select code is 1 and the value is exm_val.
- R3: When only the memory-exit instruction (mwb_*) among the valid producers writes the source register, the select code is 2 and the value is mwb_val.
- R4: When only the writeback-latch instruction (wbl_*) among the valid producers writes the source register, the select code is 3 and the value is wbl_val.
- R5: When several valid producers write the same source register, the youngest wins: exm before mwb before wbl.
- R6: A producer whose write-enable is 0 never supplies a value, even when its destination equals the source register.
- R7: A source register of 0 always gives select code 0 and the register-file data, whatever the producers hold.
- R8: Operand A and operand B are resolved independently. Each uses only its own source number and its own register-file data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 3 | Source register number of operand A |
| src_b | input | 3 | Source register number of operand B |
| rf_a | input | 32 | Register-file read data for operand A |
| rf_b | input | 32 | Register-file read data for operand B |
| exm_dst | input | 3 | Destination of the instruction in the memory stage |
| exm_we | input | 1 | That instruction writes a register |
| exm_val | input | 32 | Its ALU result |
| mwb_dst | input | 3 | Destination of the instruction leaving memory |
| mwb_we | input | 1 | That instruction writes a register |
| mwb_val | input | 32 | Its ALU or load result |
| wbl_dst | input | 3 | Destination held in the writeback latch |
| wbl_we | input | 1 | That instruction writes a register |
| wbl_val | input | 32 | Its latched result |
| sel_a | output | 2 | Operand A source: 0 regfile, 1 exm, 2 mwb, 3 wbl |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | 32 | Chosen value for operand A |
| opnd_b | output | 32 | Chosen value for operand B |

## Verification
Every source number of operand A is swept against every combination of the three producer destinations and all eight write-enable patterns. This covers single producers in each slot, back-to-back writers of the same register, disabled writers that alias the source, and register 0. Operand B gets a source number that differs from operand A in most vectors. A value steered into the wrong operand, or a cross-coupled compare, therefore shows up. Each slot carries a distinct value pattern, so a wrong select and a wrong mux leg are told apart from each other.

// File: rtl/fwd_pkg.sv
// Shared sizing for the execute-stage forwarding logic.
// Assumes an eight-register machine and three in-flight producer slots.
package fwd_pkg;
    localparam int REG_W  = 3;
    localparam int DATA_W = 32;
    localparam int N_SRC  = 3;
    localparam int SEL_W  = $clog2(N_SRC + 1);
endpackage

// File: rtl/fwd_match.sv
// Compares one source register against every producer destination.
// A hit needs an enabled write and a nonzero source register.
module fwd_match #(
    parameter int RW = fwd_pkg::REG_W,
    parameter int NS = fwd_pkg::N_SRC
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] dst [NS],
    input  logic          we  [NS],
    output logic [NS-1:0] hit
);
    logic src_nz;

    // Register 0 is hard-wired to zero and is never bypassed.
    assign src_nz = (src != '0);

    for (genvar i = 0; i < NS; i++) begin : g_cmp
        // One comparator per producer slot.
        assign hit[i] = src_nz && we[i] && (dst[i] == src);
    end
endmodule

// File: rtl/fwd_prio.sv
// Youngest-first priority encoder over producer hits.
// Slot 0 is the youngest. The output is the slot index plus 1, or 0 for no hit.
module fwd_prio #(
    parameter int NS = fwd_pkg::N_SRC,
    parameter int SW = fwd_pkg::SEL_W
) (
    input  logic [NS-1:0] hit,
    output logic [SW-1:0] sel
);
    // Scan oldest to youngest so that the youngest hit is written last.
    always_comb begin
        sel = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (hit[i]) sel = SW'(i + 1);
        end
    end
endmodule

// File: rtl/fwd_operand.sv
// Resolves one ALU operand: match, prioritise, then steer the value.
// Assumes the producer arrays are ordered youngest first.
module fwd_operand #(
    parameter int RW = fwd_pkg::REG_W,
    parameter int DW = fwd_pkg::DATA_W,
    parameter int NS = fwd_pkg::N_SRC,
    parameter int SW = fwd_pkg::SEL_W
) (
    input  logic [RW-1:0] src,
    input  logic [DW-1:0] rf,
    input  logic [RW-1:0] dst [NS],
    input  logic          we  [NS],
    input  logic [DW-1:0] val [NS],
    output logic [SW-1:0] sel,
    output logic [DW-1:0] opnd
);
    logic [NS-1:0] hit;

    fwd_match #(.RW(RW), .NS(NS)) u_match (
        .src(src), .dst(dst), .we(we), .hit(hit)
    );

    fwd_prio #(.NS(NS), .SW(SW)) u_prio (
        .hit(hit), .sel(sel)
    );

    // Value multiplexer controlled by the select code.
    always_comb begin
        opnd = rf;
        for (int i = 0; i < NS; i++) begin
            if (sel == SW'(i + 1)) opnd = val[i];
        end
    end

    // Checks of the select code against the producer inputs.
    always_comb begin
        p_zero_src_r7: assert (src != '0 || (sel == '0 && opnd == rf));
        p_rf_path_r1: assert (sel != '0 || opnd == rf);
        p_young_first_r5: assert (!(src != '0 && we[0] && dst[0] == src)
                                  || (sel == SW'(1) && opnd == val[0]));
        for (int i = 0; i < NS; i++) begin
            if (sel == SW'(i + 1)) begin
                p_sel_needs_we_r6: assert (we[i] && dst[i] == src);
            end
        end
    end
endmodule

// File: rtl/operand_fwd_unit.sv
// Execute-stage bypass selection for two ALU operands.
// Assumes slot exm is the youngest producer, then mwb, then wbl.
// Purely combinational; the select codes also drive the ALU input muxes.
module operand_fwd_unit #(
    parameter int RW = fwd_pkg::REG_W,
    parameter int DW = fwd_pkg::DATA_W,
    parameter int SW = fwd_pkg::SEL_W
) (
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic [DW-1:0] rf_a,
    input  logic [DW-1:0] rf_b,
    input  logic [RW-1:0] exm_dst,
    input  logic          exm_we,
    input  logic [DW-1:0] exm_val,
    input  logic [RW-1:0] mwb_dst,
    input  logic          mwb_we,
    input  logic [DW-1:0] mwb_val,
    input  logic [RW-1:0] wbl_dst,
    input  logic          wbl_we,
    input  logic [DW-1:0] wbl_val,
    output logic [SW-1:0] sel_a,
    output logic [SW-1:0] sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);
    localparam int NS = fwd_pkg::N_SRC;
    localparam int NOP = 2;

    logic [RW-1:0] dst_arr [NS];
    logic          we_arr  [NS];
    logic [DW-1:0] val_arr [NS];
    logic [RW-1:0] src_arr [NOP];
    logic [DW-1:0] rf_arr  [NOP];
    logic [SW-1:0] sel_arr [NOP];
    logic [DW-1:0] op_arr  [NOP];

    // Gather the producer slots, youngest first.
    assign dst_arr[0] = exm_dst;
    assign dst_arr[1] = mwb_dst;
    assign dst_arr[2] = wbl_dst;
    assign we_arr[0]  = exm_we;
    assign we_arr[1]  = mwb_we;
    assign we_arr[2]  = wbl_we;
    assign val_arr[0] = exm_val;
    assign val_arr[1] = mwb_val;
    assign val_arr[2] = wbl_val;

    // Gather the per-operand inputs.
    assign src_arr[0] = src_a;
    assign src_arr[1] = src_b;
    assign rf_arr[0]  = rf_a;
    assign rf_arr[1]  = rf_b;

    for (genvar k = 0; k < NOP; k++) begin : g_op
        fwd_operand #(.RW(RW), .DW(DW), .NS(NS), .SW(SW)) u_opnd (
            .src(src_arr[k]), .rf(rf_arr[k]),
            .dst(dst_arr), .we(we_arr), .val(val_arr),
            .sel(sel_arr[k]), .opnd(op_arr[k])
        );
    end

    // Drive the operand outputs.
    assign sel_a  = sel_arr[0];
    assign sel_b  = sel_arr[1];
    assign opnd_a = op_arr[0];
    assign opnd_b = op_arr[1];

    // Operand B must not follow operand A's source number.
    always_comb begin
        p_indep_r8: assert (src_a != src_b || (sel_a == sel_b));
    end
endmodule

// File: tb/operand_fwd_unit_bench.sv
// Exhaustive sweep of the forwarding unit with an arithmetic reference model.
module operand_fwd_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [2:0]  src_a, src_b, exm_dst, mwb_dst, wbl_dst;
    logic        exm_we, mwb_we, wbl_we;
    logic [31:0] rf_a, rf_b, exm_val, mwb_val, wbl_val, opnd_a, opnd_b;
    logic [1:0]  sel_a, sel_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    operand_fwd_unit u_operand_fwd_unit (
        .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
        .exm_dst(exm_dst), .exm_we(exm_we), .exm_val(exm_val),
        .mwb_dst(mwb_dst), .mwb_we(mwb_we), .mwb_val(mwb_val),
        .wbl_dst(wbl_dst), .wbl_we(wbl_we), .wbl_val(wbl_val),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Reference select: youngest enabled writer of src, never for register 0.
    function automatic int ref_sel(input int s, input int d0, d1, d2, input int w);
        if (s == 0) return 0;
        if (w[0] && d0 == s) return 1;
        if (w[1] && d1 == s) return 2;
        if (w[2] && d2 == s) return 3;
        return 0;
    endfunction

    // Pick the requirement tag that a vector exercises.
    function automatic string ref_tag(input int s, input int d0, d1, d2, input int w);
        int nm, ndis;
        nm = 0;
        ndis = 0;
        if (s == 0) return "R7";
        if (d0 == s) begin if (w[0]) nm++; else ndis++; end
        if (d1 == s) begin if (w[1]) nm++; else ndis++; end
        if (d2 == s) begin if (w[2]) nm++; else ndis++; end
        if (nm > 1) return "R5";
        if (nm == 0 && ndis > 0) return "R6";
        case (ref_sel(s, d0, d1, d2, w))
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        src_a = '0; src_b = '0; rf_a = '0; rf_b = '0;
        exm_dst = '0; mwb_dst = '0; wbl_dst = '0;
        exm_we = 1'b0; mwb_we = 1'b0; wbl_we = 1'b0;
        exm_val = '0; mwb_val = '0; wbl_val = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: no writers, so both operands come from the register file (R1).
        rf_a = 32'h1234_5678;
        rf_b = 32'h9abc_def0;
        @(negedge clk);
        chk("R1", "idle sel_a", 32'(sel_a), 0);
        chk("R1", "idle opnd_b", opnd_b, 32'h9abc_def0);
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 512; d++) begin
                for (int w = 0; w < 8; w++) begin
                    int d0, d1, d2, sb, ea, eb;
                    logic [31:0] va, vb;
                    logic [31:0] pv [4];
                    @(posedge clk);
                    d0 = d % 8;
                    d1 = (d / 8) % 8;
                    d2 = d / 64;
                    sb = (s + d + 3) % 8;
                    src_a = 3'(s); src_b = 3'(sb);
                    exm_dst = 3'(d0); mwb_dst = 3'(d1); wbl_dst = 3'(d2);
                    exm_we = w[0]; mwb_we = w[1]; wbl_we = w[2];
                    pv[0] = 32'hA000_0000 + 32'(d * 8 + w);
                    pv[1] = 32'h1100_0000 + 32'(d * 8 + w);
                    pv[2] = 32'h2200_0000 + 32'(s * 4096 + d);
                    pv[3] = 32'h3300_0000 + 32'(w * 65536 + d);
                    rf_a = pv[0];
                    rf_b = ~pv[0];
                    exm_val = pv[1]; mwb_val = pv[2]; wbl_val = pv[3];
                    @(negedge clk);
                    ea = ref_sel(s, d0, d1, d2, w);
                    eb = ref_sel(sb, d0, d1, d2, w);
                    va = (ea == 0) ? pv[0] : pv[ea];
                    vb = (eb == 0) ? ~pv[0] : pv[eb];
                    chk(ref_tag(s, d0, d1, d2, w), "sel_a", 32'(sel_a), 32'(ea));
                    chk(ref_tag(s, d0, d1, d2, w), "opnd_a", opnd_a, va);
                    chk("R8", "sel_b", 32'(sel_b), 32'(eb));
                    chk("R8", "opnd_b", opnd_b, vb);
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule